// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block listens on the control side of a DDR SDRAM command bus. On every rising clock edge it samples chip select, the three strobe pins (RAS, CAS, WE, all active low), clock enable, a bank address and the address bus. It turns the pin pattern into a command code and keeps a record of which of the four banks are open. For each bank it keeps the row that was given when the bank was opened.

For column accesses the block reports the column, the bank, the direction and whether an auto-precharge was asked for. It rejects accesses to an idle bank and activates to an open bank. Clock enable works as a freeze: after clock enable is sampled low, the next edges leave every piece of tracked state unchanged. The block also reports whether that freeze is a plain clock suspend or a power-down entry, which needs all banks to be idle.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: When cs_n is sampled high, no bank state or row changes, and `cmd` keeps its value.
- R2: cs_n, ras_n low with cas_n, we_n high (activate) opens bank `ba` and stores `addr` as that bank's row in `bank_row[ba]`.
- R3: cs_n, ras_n, we_n low with cas_n high and addr[10] low (precharge) returns bank `ba` to idle and leaves the other banks as they were.
- R4: The precharge pattern with addr[10] high returns all four banks to idle.
- R5: cs_n, cas_n low with ras_n high is a column access: read when we_n is high, write when we_n is low. A legal access sets `col_valid` for exactly one cycle, with `col`=addr[9:0], `col_bank`=`ba` and `is_write` giving the direction.
- R6: A legal access with addr[10] high sets `auto_pre`. Its bank stays open in the cycle after the command and is idle one cycle later.
- R7: After each accepted command, `cmd` shows its code: 0 no-op (ras_n, cas_n, we_n all high), 1 activate, 2 read, 3 write, 4 precharge, 5 mode-register load (all three low), 6 any other pattern.
- R8: A read or write to an idle bank sets `illegal` for one cycle, leaves `col_valid` low and changes no bank state.
- R9: An activate to a bank that is already open sets `illegal` for one cycle and keeps that bank's stored row.
- R10: When cke is sampled low at an edge, the following edges ignore all commands and hold every output except the mode flags. This lasts until one edge after cke is sampled high again.
- R11: When cke is sampled low while it was high at the edge before, `power_down` is set if no bank will be open after that edge and no auto-precharge is pending. Otherwise `clk_suspend` is set. Both flags clear at the first edge where cke is sampled high.
- R12: After reset all banks are idle, `cmd` is 0, and `col_valid`, `illegal`, `clk_suspend` and `power_down` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples all inputs |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row / column address, bit 10 selects auto or all-bank precharge |
| bank_open | output | 4 | One bit per bank, high when open |
| bank_row | output | 4x13 | Row stored for each bank |
| cmd | output | 3 | Code of the last accepted command |
| col_valid | output | 1 | Pulse for a legal read or write |
| col | output | 10 | Column of the last legal access |
| col_bank | output | 2 | Bank of the last legal access |
| is_write | output | 1 | Last legal access was a write |
| auto_pre | output | 1 | Last legal access requested auto-precharge |
| illegal | output | 1 | Pulse for a command that conflicts with bank state |
| clk_suspend | output | 1 | Frozen with at least one bank open |
| power_down | output | 1 | Frozen with all banks idle |

## Verification
The hardest case to reach is a freeze that starts on the same edge as a column access. In that case the access pulse and the mode flag have to stay put through edges that carry conflicting commands, and the block stays deaf for one more edge after cke rises again. The stimulus opens a bank, lowers cke together with a read, and then sends a precharge-all while cke is low. The bench checks that the bank is still open and that the access pulse is still high. It then checks that the first edge with cke high again clears the flag, and that only the edge after that one lets the pulse fall.

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker #(
  parameter int BAW    = 2,
  parameter int AW     = 13,
  parameter int CW     = 10,
  parameter int AP_BIT = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cs_n,
  input  logic                          ras_n,
  input  logic                          cas_n,
  input  logic                          we_n,
  input  logic                          cke,
  input  logic [BAW-1:0]                ba,
  input  logic [AW-1:0]                 addr,
  output logic [(1<<BAW)-1:0]           bank_open,
  output logic [(1<<BAW)-1:0][AW-1:0]   bank_row,
  output logic [2:0]                    cmd,
  output logic                          col_valid,
  output logic [CW-1:0]                 col,
  output logic [BAW-1:0]                col_bank,
  output logic                          is_write,
  output logic                          auto_pre,
  output logic                          illegal,
  output logic                          clk_suspend,
  output logic                          power_down
);
  localparam int NB = 1 << BAW;

  logic           cke_q, ap_pend;
  logic [BAW-1:0] ap_bank;
  logic [NB-1:0]  open_d;
  logic [2:0]     code;

  wire       go     = cke_q & ~cs_n;
  wire [2:0] pins   = {ras_n, cas_n, we_n};
  wire       is_act = go && pins == 3'b011;
  wire       is_pre = go && pins == 3'b010;
  wire       is_rd  = go && pins == 3'b101;
  wire       is_wr  = go && pins == 3'b100;
  wire       hit    = bank_open[ba];
  wire       act_ok = is_act & ~hit;
  wire       rw_ok  = (is_rd | is_wr) & hit;
  wire       bad    = (is_act & hit) | ((is_rd | is_wr) & ~hit);
  wire       ap_new = rw_ok & addr[AP_BIT];

  always_comb begin
    case (pins)
      3'b111:  code = 3'd0;
      3'b011:  code = 3'd1;
      3'b101:  code = 3'd2;
      3'b100:  code = 3'd3;
      3'b010:  code = 3'd4;
      3'b000:  code = 3'd5;
      default: code = 3'd6;
    endcase
  end

  always_comb begin
    open_d = bank_open;
    if (cke_q) begin
      if (ap_pend) open_d[ap_bank] = 1'b0;
      if (act_ok) open_d[ba] = 1'b1;
      if (is_pre) begin
        if (addr[AP_BIT]) open_d = '0;
        else open_d[ba] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q     <= 1'b1;
      bank_open <= '0;
      ap_pend   <= 1'b0;
      ap_bank   <= '0;
      cmd       <= 3'd0;
      col_valid <= 1'b0;
      col       <= '0;
      col_bank  <= '0;
      is_write  <= 1'b0;
      auto_pre  <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      cke_q <= cke;
      if (cke_q) begin
        bank_open <= open_d;
        ap_pend   <= ap_new;
        ap_bank   <= ba;
        col_valid <= rw_ok;
        illegal   <= bad;
        if (go) cmd <= code;
        if (rw_ok) begin
          col      <= addr[CW-1:0];
          col_bank <= ba;
          is_write <= is_wr;
          auto_pre <= addr[AP_BIT];
        end
      end
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_row[b] <= '0;
      else if (act_ok && ba == BAW'(b)) bank_row[b] <= addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_suspend <= 1'b0;
      power_down  <= 1'b0;
    end else if (cke) begin
      clk_suspend <= 1'b0;
      power_down  <= 1'b0;
    end else if (cke_q) begin
      power_down  <= (open_d == '0) && !ap_new;
      clk_suspend <= !((open_d == '0) && !ap_new);
    end
  end

  assert_desel_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && cke_q && !ap_pend) |=> ($stable(bank_open) && $stable(bank_row) && $stable(cmd)));

  assert_ap_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && auto_pre && cke_q) |=> !bank_open[$past(col_bank)]);

  assert_act_open_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && hit) |=> (illegal && $stable(bank_row)));

  assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |=> ($stable(bank_open) && $stable(col) && $stable(cmd) && $stable(col_valid)));

  assert_pd_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |-> (bank_open == '0 && !clk_suspend));
endmodule

// File: tb/sim_sdram_cmd_tracker.sv
module sim_sdram_cmd_tracker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [1:0] ba = '0;
  logic [12:0] addr = '0;
  logic [3:0] bank_open;
  logic [3:0][12:0] bank_row;
  logic [2:0] cmd;
  logic col_valid, is_write, auto_pre, illegal, clk_suspend, power_down;
  logic [9:0] col;
  logic [1:0] col_bank;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  sdram_cmd_tracker u0 (.clk, .rst_n, .cs_n, .ras_n, .cas_n, .we_n, .cke, .ba, .addr,
    .bank_open, .bank_row, .cmd, .col_valid, .col, .col_bank, .is_write, .auto_pre,
    .illegal, .clk_suspend, .power_down);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(logic c, logic r, logic ca, logic w, logic [1:0] b, logic [12:0] a, logic k);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr = a; cke = k;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic nop(logic k = 1'b1); issue(0, 1, 1, 1, 0, 0, k); endtask

  task automatic t_reset();
    chk("R12 open", bank_open, 0); chk("R12 cmd", cmd, 0);
    chk("R12 flags", {col_valid, illegal, clk_suspend, power_down}, 0);
  endtask

  task automatic t_activate();
    issue(0, 0, 1, 1, 1, 13'h1ABC, 1);
    chk("R2 open", bank_open, 4'b0010); chk("R2 row", bank_row[1], 13'h1ABC); chk("R7 act", cmd, 1);
    issue(0, 0, 1, 1, 2, 13'h0005, 1);
    chk("R2 open2", bank_open, 4'b0110); chk("R2 row2", bank_row[2], 13'h0005);
  endtask

  task automatic t_deselect();
    issue(1, 0, 1, 1, 3, 13'h0777, 1);
    chk("R1 act ignored", bank_open, 4'b0110); chk("R1 row", bank_row[3], 0); chk("R1 cmd", cmd, 1);
    issue(1, 0, 1, 0, 1, 0, 1);
    chk("R1 pre ignored", bank_open, 4'b0110);
  endtask

  task automatic t_column();
    issue(0, 1, 0, 1, 1, 13'h02A5, 1);
    chk("R5 valid", col_valid, 1); chk("R5 col", col, 10'h2A5); chk("R5 bank", col_bank, 1);
    chk("R5 dir", is_write, 0); chk("R7 rd", cmd, 2); chk("R6 no ap", auto_pre, 0);
    nop(); chk("R5 pulse", col_valid, 0); chk("R7 nop", cmd, 0);
    issue(0, 1, 0, 0, 2, 13'h03FF, 1);
    chk("R5 wr", {is_write, col_bank, col}, {1'b1, 2'd2, 10'h3FF}); chk("R7 wr", cmd, 3);
  endtask

  task automatic t_illegal();
    issue(0, 1, 0, 1, 0, 13'h0011, 1);
    chk("R8 flag", illegal, 1); chk("R8 no col", col_valid, 0); chk("R8 state", bank_open, 4'b0110);
    issue(0, 0, 1, 1, 1, 13'h0123, 1);
    chk("R9 flag", illegal, 1); chk("R9 row kept", bank_row[1], 13'h1ABC);
    nop(); chk("R8 pulse", illegal, 0);
  endtask

  task automatic t_autopre();
    issue(0, 1, 0, 1, 1, 13'h0412, 1);
    chk("R6 flag", auto_pre, 1); chk("R6 still open", bank_open[1], 1);
    nop(); chk("R6 closed", bank_open, 4'b0100);
  endtask

  task automatic t_precharge();
    issue(0, 0, 1, 0, 2, 0, 1);
    chk("R3 single", bank_open, 0); chk("R7 pre", cmd, 4);
    issue(0, 0, 1, 1, 0, 1, 1); issue(0, 0, 1, 1, 3, 2, 1);
    chk("R4 setup", bank_open, 4'b1001);
    issue(0, 0, 1, 0, 1, 13'h0400, 1);
    chk("R4 all", bank_open, 0);
  endtask

  task automatic t_codes();
    issue(0, 0, 0, 0, 0, 0, 1); chk("R7 mrs", cmd, 5);
    issue(0, 0, 0, 1, 0, 0, 1); chk("R7 other", cmd, 6);
    nop(); chk("R7 nop2", cmd, 0);
  endtask

  task automatic t_suspend();
    issue(0, 0, 1, 1, 0, 13'h0042, 1);
    issue(0, 1, 0, 1, 0, 13'h0007, 0);
    chk("R11 suspend", {clk_suspend, power_down}, 2'b10); chk("R5 col in freeze", col_valid, 1);
    issue(0, 0, 1, 0, 0, 13'h0400, 0);
    chk("R10 pre frozen", bank_open, 4'b0001); chk("R10 pulse held", col_valid, 1); chk("R10 cmd", cmd, 2);
    nop(1);
    chk("R11 cleared", {clk_suspend, power_down}, 0); chk("R10 still frozen", col_valid, 1);
    nop(1); chk("R10 resumed", col_valid, 0);
    issue(0, 0, 1, 0, 0, 0, 1); chk("R3 pre b0", bank_open, 0);
  endtask

  task automatic t_powerdown();
    nop(0);
    chk("R11 pd", {clk_suspend, power_down}, 2'b01);
    issue(0, 0, 1, 1, 2, 13'h0099, 0);
    chk("R10 act ignored", bank_open, 0); chk("R10 row", bank_row[2], 13'h0005);
    nop(1); chk("R11 pd exit", power_down, 0);
    nop(1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset(); t_activate(); t_deselect(); t_column(); t_illegal();
        t_autopre(); t_precharge(); t_codes(); t_suspend(); t_powerdown();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule